// File: doc/BRIEF.md
# Program-Load Mode Controller

This block sits between the pins of a device with 32 KB of on-chip nonvolatile memory and that memory's write and read ports. It recognises a request to enter program-load mode, works out which parallel load cycle the control pins ask for, times the program strobe, and opens the verify output window once the data has had time to settle. It also keeps the partition settings and the security lock that those cycles change.

The block counts a power-on delay after reset. After that delay it enters load mode when the device reset pin is high and the program-store pin is low. In load mode, a programming-voltage flag and three mode pins taken from the high port select the cycle. The cycle starts on a falling edge of the program strobe. It takes effect only if the strobe stays low for the full pulse time. Verify cycles need no programming voltage. They present data on the verify output once the address has been stable for a set delay, which is longer for the expanded 32 KB space. The nonvolatile array and the encryption hardware are outside this block. It only issues commands to them.

Top module: `prog_load_ctrl`

## Requirements
- R1: `load_mode` is 0 while `rst` is high and stays 0 for at least POR_CYCLES clocks after reset. After that delay it rises when `pin_reset`=1 and `pin_pstore_n`=0 together, and it falls when `pin_reset` goes low. No program cycle has any effect outside load mode.
- R2: With `vpp_on`=1 and `mode_sel`=3'b10x, a strobe held low for PGM_PULSE clocks gives exactly one `mem_we` pulse. The pulse carries `mem_addr`={`addr_hi`[3:0],`addr_lo`} (12 bits, zero-extended) and `mem_wdata`=`data_in`.
- R3: With `vpp_on`=1 and `mode_sel`=3'b010, the same strobe writes at the 15-bit address {`addr_hi`[6:0],`addr_lo`}.
- R4: If the strobe rises before PGM_PULSE clocks have passed, no write or register update happens.
- R5: After an accepted program cycle, a new strobe is ignored until `vpp_on` has been 0 for VPP_GAP consecutive clocks.
- R6: With `vpp_on`=1, `mode_sel`=3'b00x is not a valid code. Its strobe gives no `mem_wdata` write and no other update.
- R7: The first program-byte or security-set cycle after `rst` sets `part_range32`=0 and `part_bound`=2 (a 4 KB program area, in 2 KB units). Later cycles do not apply this default again. The reset values are `part_range32`=1 and `part_bound`=0.
- R8: With `vpp_on`=1 and `mode_sel`=3'b011, `addr_hi` must be 00h. Then `addr_lo`=00h writes the control byte (bit0 lock, bit1 range32, bits[5:2] bound), and `addr_lo`=01h..05h pulses `key_we` with `key_idx`=`addr_lo`[2:0]. Any other address is ignored.
- R9: A security-set cycle (`vpp_on`=1, `mode_sel`=3'b11x), or a control-byte write with bit0=1, sets `sec_lock`. Only `rst` clears it.
- R10: A normal verify (`vpp_on`=0, `mode_sel`=3'b00x) raises `vfy_oe` no earlier than VFY_DLY clocks after the address last changed. `vfy_data` then carries memory at the 12-bit address, and `vfy_oe` drops within two clocks of an address change.
- R11: An expanded verify (`vpp_on`=0, `mode_sel`=3'b010, strobe high) reads the 15-bit address and needs VFY_DLY_EXP stable clocks.
- R12: A control verify (`vpp_on`=0, `mode_sel`=3'b011, strobe high) returns the control byte, with bit0 equal to `sec_lock`.
- R13: While `sec_lock`=1, memory verifies return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_reset | input | 1 | Device reset pin, active high |
| pin_pstore_n | input | 1 | Program-store pin, pulled low to request load mode |
| pin_strobe_n | input | 1 | Program strobe, active low |
| vpp_on | input | 1 | Programming voltage present |
| mode_sel | input | 3 | High-port mode pins {P7,P6,P5} |
| addr_lo | input | 8 | Low address byte |
| addr_hi | input | 8 | High address byte |
| data_in | input | 8 | Program data |
| mem_rdata | input | 8 | Read data from the memory array |
| load_mode | output | 1 | Load mode active |
| mem_we | output | 1 | Memory write pulse |
| mem_re | output | 1 | Memory read enable during memory verify |
| mem_addr | output | MEM_AW | Memory address |
| mem_wdata | output | 8 | Write data for memory or key register |
| key_we | output | 1 | Key register write pulse |
| key_idx | output | KIW | Key register number, 1 to KEY_COUNT |
| vfy_oe | output | 1 | Verify data drive enable |
| vfy_data | output | 8 | Verify data |
| part_range32 | output | 1 | 1: 32 KB range, 0: 8 KB range |
| part_bound | output | 4 | Program/data boundary in 2 KB units |
| sec_lock | output | 1 | Security lock |

## Verification
A table of program cycles tries the two write codes, both invalid codes, a key write, and a register write with a nonzero high byte. Each entry checks whether a write happened and at which address, which separates the 12-bit address from the 15-bit one and memory writes from key writes. Directed runs hold the strobe too briefly, reapply voltage too soon, and read the verify output before and after its window, which separates the normal and expanded delays. The lock is then set by each of its two routes, and the runs show that memory verifies read zero while the control byte still reads back.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_PGM,
    CYC_SEC,
    CYC_EXP,
    CYC_REG
  } pcyc_t;

  typedef enum logic [1:0] {
    VK_NORM,
    VK_EXP,
    VK_CTL
  } vkind_t;

  // mode pins are {P7,P6,P5}, valid only with programming voltage present
  function automatic pcyc_t pgm_decode(input logic [2:0] m);
    if (m[2])      return m[1] ? CYC_SEC : CYC_PGM;
    else if (m[1]) return m[0] ? CYC_REG : CYC_EXP;
    else           return CYC_NONE;
  endfunction

  function automatic vkind_t vfy_decode(input logic [2:0] m);
    if (!m[1])    return VK_NORM;
    else if (m[0]) return VK_CTL;
    else           return VK_EXP;
  endfunction

endpackage

// File: rtl/plc_por.sv
module plc_por #(
  parameter int POR_CYCLES = 21504
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_reset,
  input  logic pin_pstore_n,
  output logic load_mode
);
  localparam int W = $clog2(POR_CYCLES + 1);

  logic [W-1:0] cnt;
  logic         done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      done      <= 1'b0;
      load_mode <= 1'b0;
    end else begin
      if (!done) begin
        cnt <= cnt + 1'b1;
        if (cnt == W'(POR_CYCLES - 1)) done <= 1'b1;
      end
      if (!pin_reset)                    load_mode <= 1'b0;
      else if (done && !pin_pstore_n)    load_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/plc_pgm.sv
module plc_pgm
  import plc_pkg::*;
#(
  parameter int PGM_PULSE = 2400,
  parameter int VPP_GAP   = 1200,
  parameter int MEM_AW    = 15,
  parameter int NORM_AW   = 12,
  parameter int KEY_COUNT = 5,
  parameter int KIW       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mode,
  input  logic              pin_strobe_n,
  input  logic              vpp_on,
  input  logic [2:0]        mode_sel,
  input  logic [7:0]        addr_lo,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        data_in,
  output logic              mem_we,
  output logic [MEM_AW-1:0] waddr,
  output logic [7:0]        wdata,
  output logic              key_we,
  output logic [KIW-1:0]    key_idx,
  output logic              ctl_we,
  output logic              sec_set,
  output logic              dflt_hit
);
  localparam int PW = $clog2(PGM_PULSE + 1);
  localparam int GW = $clog2(VPP_GAP + 1);

  typedef enum logic [1:0] {PS_IDLE, PS_LOW, PS_WAIT} pst_t;

  pst_t          st;
  logic [PW-1:0] cnt;
  logic [GW-1:0] gap_cnt;
  logic          armed;
  logic          strobe_q;
  pcyc_t         lat_cyc;
  logic [7:0]    lat_lo, lat_hi, lat_dat;
  pcyc_t         cyc;
  logic          accept;

  assign cyc    = pgm_decode(mode_sel);
  assign accept = (st == PS_IDLE) && strobe_q && !pin_strobe_n && load_mode &&
                  vpp_on && armed && (cyc != CYC_NONE);

  // voltage-off interval between cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      armed   <= 1'b1;
    end else begin
      if (vpp_on) gap_cnt <= '0;
      else if (gap_cnt != GW'(VPP_GAP)) gap_cnt <= gap_cnt + 1'b1;
      if (accept) armed <= 1'b0;
      else if (!vpp_on && gap_cnt == GW'(VPP_GAP - 1)) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PS_IDLE;
      cnt      <= '0;
      strobe_q <= 1'b1;
      lat_cyc  <= CYC_NONE;
      lat_lo   <= '0;
      lat_hi   <= '0;
      lat_dat  <= '0;
      mem_we   <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
      key_we   <= 1'b0;
      key_idx  <= '0;
      ctl_we   <= 1'b0;
      sec_set  <= 1'b0;
      dflt_hit <= 1'b0;
    end else begin
      strobe_q <= pin_strobe_n;
      mem_we   <= 1'b0;
      key_we   <= 1'b0;
      ctl_we   <= 1'b0;
      sec_set  <= 1'b0;
      dflt_hit <= 1'b0;
      unique case (st)
        PS_IDLE: if (accept) begin
          st      <= PS_LOW;
          cnt     <= PW'(1);
          lat_cyc <= cyc;
          lat_lo  <= addr_lo;
          lat_hi  <= addr_hi;
          lat_dat <= data_in;
        end
        PS_LOW: begin
          if (pin_strobe_n)                st <= PS_IDLE;
          else if (!vpp_on || !load_mode)  st <= PS_WAIT;
          else if (cnt == PW'(PGM_PULSE)) begin
            st    <= PS_WAIT;
            wdata <= lat_dat;
            unique case (lat_cyc)
              CYC_PGM: begin
                mem_we   <= 1'b1;
                waddr    <= MEM_AW'({lat_hi[NORM_AW-9:0], lat_lo});
                dflt_hit <= 1'b1;
              end
              CYC_EXP: begin
                mem_we <= 1'b1;
                waddr  <= {lat_hi[MEM_AW-9:0], lat_lo};
              end
              CYC_SEC: begin
                sec_set  <= 1'b1;
                dflt_hit <= 1'b1;
              end
              CYC_REG: if (lat_hi == 8'h00) begin
                if (lat_lo == 8'h00) ctl_we <= 1'b1;
                else if (lat_lo <= 8'(KEY_COUNT)) begin
                  key_we  <= 1'b1;
                  key_idx <= lat_lo[KIW-1:0];
                end
              end
              default: ;
            endcase
          end else cnt <= cnt + 1'b1;
        end
        PS_WAIT: if (pin_strobe_n) st <= PS_IDLE;
        default: st <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plc_vfy.sv
module plc_vfy
  import plc_pkg::*;
#(
  parameter int VFY_DLY     = 48,
  parameter int VFY_DLY_EXP = 1800,
  parameter int MEM_AW      = 15,
  parameter int NORM_AW     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mode,
  input  logic              pin_strobe_n,
  input  logic              vpp_on,
  input  logic [2:0]        mode_sel,
  input  logic [7:0]        addr_lo,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        ctl_rd,
  input  logic              sec_lock,
  output logic              mem_re,
  output logic [MEM_AW-1:0] raddr,
  output logic              vfy_oe,
  output logic [7:0]        vfy_data
);
  localparam int MAXD = (VFY_DLY_EXP > VFY_DLY) ? VFY_DLY_EXP : VFY_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  vkind_t        kind;
  logic          active, act_q, changed, ready;
  logic [17:0]   key, key_q;
  logic [CW-1:0] cnt, lim;

  assign kind    = vfy_decode(mode_sel);
  assign active  = load_mode && !vpp_on && !mode_sel[2] &&
                   (!mode_sel[1] || pin_strobe_n);
  assign key     = {kind, addr_hi, addr_lo};
  assign changed = !active || !act_q || (key != key_q);
  assign lim     = (kind == VK_EXP) ? CW'(VFY_DLY_EXP) : CW'(VFY_DLY);
  assign ready   = !changed && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      key_q    <= '0;
      cnt      <= '0;
      mem_re   <= 1'b0;
      raddr    <= '0;
      vfy_oe   <= 1'b0;
      vfy_data <= '0;
    end else begin
      act_q  <= active;
      key_q  <= key;
      if (changed)         cnt <= '0;
      else if (cnt != lim) cnt <= cnt + 1'b1;
      mem_re <= active && (kind != VK_CTL);
      raddr  <= (kind == VK_EXP) ? {addr_hi[MEM_AW-9:0], addr_lo}
                                 : MEM_AW'({addr_hi[NORM_AW-9:0], addr_lo});
      vfy_oe <= ready;
      if (ready) begin
        if (kind == VK_CTL) vfy_data <= ctl_rd;
        else                vfy_data <= sec_lock ? 8'h00 : mem_rdata;
      end
    end
  end
endmodule

// File: rtl/plc_cfg.sv
module plc_cfg #(
  parameter int DFLT_BOUND = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       sec_set,
  input  logic       dflt_hit,
  output logic       part_range32,
  output logic [3:0] part_bound,
  output logic       sec_lock,
  output logic [7:0] ctl_rd
);
  // control byte: [0] lock, [1] range32, [5:2] bound, [7:6] spare
  logic [7:0] ctl;
  logic       first_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl        <= 8'h02;
      first_done <= 1'b0;
    end else begin
      if (ctl_we) ctl[7:1] <= ctl_wdata[7:1];
      if (sec_set || (ctl_we && ctl_wdata[0])) ctl[0] <= 1'b1;
      if (dflt_hit && !first_done) begin
        first_done <= 1'b1;
        ctl[1]     <= 1'b0;
        ctl[5:2]   <= 4'(DFLT_BOUND);
      end
    end
  end

  assign part_range32 = ctl[1];
  assign part_bound   = ctl[5:2];
  assign sec_lock     = ctl[0];
  assign ctl_rd       = ctl;
endmodule

// File: rtl/prog_load_ctrl.sv
module prog_load_ctrl #(
  parameter int POR_CYCLES  = 21504,
  parameter int PGM_PULSE   = 2400,
  parameter int VPP_GAP     = 1200,
  parameter int VFY_DLY     = 48,
  parameter int VFY_DLY_EXP = 1800,
  parameter int MEM_AW      = 15,
  parameter int NORM_AW     = 12,
  parameter int KEY_COUNT   = 5,
  localparam int KIW        = $clog2(KEY_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_reset,
  input  logic              pin_pstore_n,
  input  logic              pin_strobe_n,
  input  logic              vpp_on,
  input  logic [2:0]        mode_sel,
  input  logic [7:0]        addr_lo,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        data_in,
  input  logic [7:0]        mem_rdata,
  output logic              load_mode,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              key_we,
  output logic [KIW-1:0]    key_idx,
  output logic              vfy_oe,
  output logic [7:0]        vfy_data,
  output logic              part_range32,
  output logic [3:0]        part_bound,
  output logic              sec_lock
);
  logic [MEM_AW-1:0] waddr, raddr;
  logic              ctl_we, sec_set, dflt_hit;
  logic [7:0]        ctl_rd;

  plc_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .pin_reset(pin_reset),
    .pin_pstore_n(pin_pstore_n), .load_mode(load_mode)
  );

  plc_pgm #(
    .PGM_PULSE(PGM_PULSE), .VPP_GAP(VPP_GAP), .MEM_AW(MEM_AW),
    .NORM_AW(NORM_AW), .KEY_COUNT(KEY_COUNT), .KIW(KIW)
  ) u_pgm (
    .clk(clk), .rst(rst), .load_mode(load_mode), .pin_strobe_n(pin_strobe_n),
    .vpp_on(vpp_on), .mode_sel(mode_sel), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .data_in(data_in), .mem_we(mem_we), .waddr(waddr), .wdata(mem_wdata),
    .key_we(key_we), .key_idx(key_idx), .ctl_we(ctl_we), .sec_set(sec_set),
    .dflt_hit(dflt_hit)
  );

  plc_vfy #(
    .VFY_DLY(VFY_DLY), .VFY_DLY_EXP(VFY_DLY_EXP), .MEM_AW(MEM_AW), .NORM_AW(NORM_AW)
  ) u_vfy (
    .clk(clk), .rst(rst), .load_mode(load_mode), .pin_strobe_n(pin_strobe_n),
    .vpp_on(vpp_on), .mode_sel(mode_sel), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .mem_rdata(mem_rdata), .ctl_rd(ctl_rd), .sec_lock(sec_lock),
    .mem_re(mem_re), .raddr(raddr), .vfy_oe(vfy_oe), .vfy_data(vfy_data)
  );

  plc_cfg #(.DFLT_BOUND(2)) u_cfg (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(mem_wdata),
    .sec_set(sec_set), .dflt_hit(dflt_hit), .part_range32(part_range32),
    .part_bound(part_bound), .sec_lock(sec_lock), .ctl_rd(ctl_rd)
  );

  assign mem_addr = mem_we ? waddr : raddr;
endmodule

// File: rtl/plc_chk.sv
module plc_chk #(
  parameter int POR_CYCLES = 21504,
  parameter int VFY_DLY    = 48
) (
  input logic       clk,
  input logic       rst,
  input logic       pin_reset,
  input logic       pin_pstore_n,
  input logic       pin_strobe_n,
  input logic       vpp_on,
  input logic [7:0] addr_lo,
  input logic [7:0] addr_hi,
  input logic       load_mode,
  input logic       mem_we,
  input logic       mem_re,
  input logic       vfy_oe,
  input logic [7:0] vfy_data,
  input logic       sec_lock
);
  localparam int SW = $clog2(POR_CYCLES + 2);
  localparam int AW = $clog2(VFY_DLY + 2);

  logic [SW-1:0] since_rst;
  logic [AW-1:0] stable_cnt;
  logic [15:0]   addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst  <= '0;
      stable_cnt <= '0;
      addr_q     <= '0;
    end else begin
      if (since_rst != SW'(POR_CYCLES + 1)) since_rst <= since_rst + 1'b1;
      addr_q <= {addr_hi, addr_lo};
      if ({addr_hi, addr_lo} != addr_q)        stable_cnt <= '0;
      else if (stable_cnt != AW'(VFY_DLY + 1)) stable_cnt <= stable_cnt + 1'b1;
    end
  end

  // R1
  por_wait_chk: assert property (@(posedge clk) disable iff (rst)
    load_mode |-> since_rst >= SW'(POR_CYCLES));
  // R1
  entry_pins_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(load_mode) |-> ($past(pin_reset) && !$past(pin_pstore_n)));
  // R2
  we_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!$past(pin_strobe_n) && $past(vpp_on)));
  // R2
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sec_lock |=> sec_lock);
  // R10
  vfy_stable_chk: assert property (@(posedge clk) disable iff (rst)
    vfy_oe |-> stable_cnt >= AW'(VFY_DLY));
  // R13
  lock_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vfy_oe && $past(sec_lock) && $past(mem_re)) |-> vfy_data == 8'h00);
endmodule

bind prog_load_ctrl plc_chk #(.POR_CYCLES(POR_CYCLES), .VFY_DLY(VFY_DLY)) u_chk (
  .clk(clk), .rst(rst), .pin_reset(pin_reset), .pin_pstore_n(pin_pstore_n),
  .pin_strobe_n(pin_strobe_n), .vpp_on(vpp_on), .addr_lo(addr_lo),
  .addr_hi(addr_hi), .load_mode(load_mode), .mem_we(mem_we), .mem_re(mem_re),
  .vfy_oe(vfy_oe), .vfy_data(vfy_data), .sec_lock(sec_lock)
);

// File: tb/prog_load_ctrl_tb.sv
module prog_load_ctrl_tb;
  localparam int POR = 64, PGM = 40, GAP = 20, VD = 6, VDX = 30;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, pin_reset, pin_pstore_n, pin_strobe_n, vpp_on;
  logic [2:0] mode_sel;
  logic [7:0] addr_lo, addr_hi, data_in, mem_rdata;
  logic load_mode, mem_we, mem_re, key_we, vfy_oe, part_range32, sec_lock;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata, vfy_data;
  logic [2:0] key_idx;
  logic [3:0] part_bound;

  prog_load_ctrl #(.POR_CYCLES(POR), .PGM_PULSE(PGM), .VPP_GAP(GAP),
                   .VFY_DLY(VD), .VFY_DLY_EXP(VDX)) u_dut (.*);

  function automatic logic [7:0] memf(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  assign mem_rdata = memf(mem_addr);

  int tests = 0, fails = 0, we_cnt = 0, key_cnt = 0;
  logic [14:0] last_wa = '0;
  logic [7:0]  last_wd = '0;
  logic [2:0]  last_key = '0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_we)  begin we_cnt++; last_wa = mem_addr; last_wd = mem_wdata; end
    if (key_we)  begin key_cnt++; last_key = key_idx; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cycle(input logic v, input logic [2:0] m, input logic [7:0] hi,
                          input logic [7:0] lo, input logic [7:0] d,
                          input int hold, input int gap);
    @(negedge clk);
    mode_sel = m; addr_hi = hi; addr_lo = lo; data_in = d; vpp_on = v;
    wait_n(2);
    pin_strobe_n = 1'b0;
    wait_n(hold);
    pin_strobe_n = 1'b1;
    wait_n(3);
    vpp_on = 1'b0; mode_sel = 3'b111;
    wait_n(gap);
  endtask

  task automatic set_vfy(input logic [2:0] m, input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk);
    vpp_on = 1'b0; pin_strobe_n = 1'b1; mode_sel = m; addr_hi = hi; addr_lo = lo;
  endtask

  typedef struct packed {
    logic       vpp;
    logic [2:0] mode;
    logic [7:0] hi, lo, dat;
    logic       exp_we;
    logic [14:0] exp_addr;
    logic       exp_key;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 3'b100, 8'hF3, 8'h21, 8'hA5, 1'b1, 15'h0321, 1'b0},  // R2 program byte
    '{1'b1, 3'b010, 8'h7A, 8'h10, 8'h3C, 1'b1, 15'h7A10, 1'b0},  // R3 expanded
    '{1'b1, 3'b000, 8'h01, 8'h02, 8'h99, 1'b0, 15'h0000, 1'b0},  // R6 invalid
    '{1'b1, 3'b001, 8'h01, 8'h03, 8'h98, 1'b0, 15'h0000, 1'b0},  // R6 invalid
    '{1'b1, 3'b011, 8'h00, 8'h03, 8'h77, 1'b0, 15'h0000, 1'b1},  // R8 key 3
    '{1'b1, 3'b011, 8'h01, 8'h03, 8'h66, 1'b0, 15'h0000, 1'b0},  // R8 bad high byte
    '{1'b1, 3'b101, 8'h00, 8'h05, 8'h11, 1'b1, 15'h0005, 1'b0}   // R2 x bit set
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w0, k0;
    rst = 1; pin_reset = 0; pin_pstore_n = 1; pin_strobe_n = 1; vpp_on = 0;
    mode_sel = 3'b111; addr_lo = 0; addr_hi = 0; data_in = 0;
    wait_n(3);
    chk("R1 reset load_mode", load_mode, 0);
    chk("R1 reset vfy_oe", vfy_oe, 0);
    chk("R7 reset range", part_range32, 1);
    chk("R7 reset bound", part_bound, 0);
    chk("R9 reset lock", sec_lock, 0);
    rst = 0; pin_reset = 1; pin_pstore_n = 0;
    wait_n(POR / 2);
    chk("R1 load_mode before delay", load_mode, 0);
    wait_n(POR);
    chk("R1 load_mode after delay", load_mode, 1);

    foreach (VECS[i]) begin
      w0 = we_cnt; k0 = key_cnt;
      do_cycle(VECS[i].vpp, VECS[i].mode, VECS[i].hi, VECS[i].lo, VECS[i].dat,
               PGM + 5, GAP + 5);
      chk("R2/R3/R6/R8 write count", we_cnt - w0, VECS[i].exp_we);
      chk("R8 key count", key_cnt - k0, VECS[i].exp_key);
      if (VECS[i].exp_we) begin
        chk("R2/R3 address", last_wa, VECS[i].exp_addr);
        chk("R2/R3 data", last_wd, VECS[i].dat);
      end
      if (VECS[i].exp_key) chk("R8 key index", last_key, VECS[i].lo[2:0]);
    end

    chk("R7 default range", part_range32, 0);
    chk("R7 default bound", part_bound, 2);
    w0 = we_cnt;
    do_cycle(1, 3'b011, 8'h00, 8'h00, 8'h26, PGM + 5, GAP + 5);
    chk("R8 ctl range", part_range32, 1);
    chk("R8 ctl bound", part_bound, 9);
    chk("R8 no mem write", we_cnt - w0, 0);
    do_cycle(1, 3'b100, 8'h00, 8'h40, 8'h12, PGM + 5, GAP + 5);
    chk("R7 no second default", {part_range32, part_bound}, 5'h19);

    w0 = we_cnt;
    do_cycle(1, 3'b100, 8'h00, 8'h41, 8'h13, PGM / 2, GAP + 5);
    chk("R4 short strobe", we_cnt - w0, 0);

    w0 = we_cnt;
    do_cycle(1, 3'b100, 8'h00, 8'h42, 8'h14, PGM + 5, GAP / 2);
    do_cycle(1, 3'b100, 8'h00, 8'h43, 8'h15, PGM + 5, GAP + 5);
    chk("R5 early cycle ignored", we_cnt - w0, 1);
    chk("R5 kept first address", last_wa, 15'h0042);
    do_cycle(1, 3'b100, 8'h00, 8'h44, 8'h16, PGM + 5, GAP + 5);
    chk("R5 accepted after gap", last_wa, 15'h0044);

    set_vfy(3'b000, 8'h02, 8'h34);
    wait_n(3);
    chk("R10 not early", vfy_oe, 0);
    wait_n(VD + 1);
    chk("R10 oe", vfy_oe, 1);
    chk("R10 data", vfy_data, memf(15'h0234));
    set_vfy(3'b000, 8'h02, 8'h35);
    wait_n(2);
    chk("R10 drop on change", vfy_oe, 0);
    set_vfy(3'b010, 8'h55, 8'h66);
    wait_n(VD + 4);
    chk("R11 not at short delay", vfy_oe, 0);
    wait_n(VDX - VD + 2);
    chk("R11 oe", vfy_oe, 1);
    chk("R11 data", vfy_data, memf(15'h5566));
    set_vfy(3'b011, 8'h00, 8'h00);
    wait_n(VD + 4);
    chk("R12 ctl readback", vfy_data, 8'h26);

    do_cycle(1, 3'b110, 8'h00, 8'h00, 8'h00, PGM + 5, GAP + 5);
    chk("R9 security set", sec_lock, 1);
    set_vfy(3'b000, 8'h02, 8'h34);
    wait_n(VD + 4);
    chk("R13 oe locked", vfy_oe, 1);
    chk("R13 zero data", vfy_data, 8'h00);
    set_vfy(3'b011, 8'h00, 8'h00);
    wait_n(VD + 4);
    chk("R12 ctl shows lock", vfy_data, 8'h27);

    @(negedge clk); mode_sel = 3'b111; rst = 1;
    wait_n(2);
    rst = 0;
    chk("R9 cleared by reset", sec_lock, 0);
    wait_n(POR + 5);
    do_cycle(1, 3'b011, 8'h00, 8'h00, 8'h01, PGM + 5, GAP + 5);
    chk("R9 lock via ctl", sec_lock, 1);
    do_cycle(1, 3'b011, 8'h00, 8'h00, 8'h00, PGM + 5, GAP + 5);
    chk("R9 lock sticky", sec_lock, 1);

    @(negedge clk); pin_reset = 0;
    wait_n(2);
    chk("R1 exit", load_mode, 0);
    w0 = we_cnt;
    do_cycle(1, 3'b100, 8'h00, 8'h50, 8'h20, PGM + 5, GAP + 5);
    chk("R1 no write outside load mode", we_cnt - w0, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule